// File: doc/BRIEF.md
# Chained Multiply-Add Digit Row Unit

This block computes one row of a schoolbook multiplication of a long unsigned integer. Every 64-bit digit of a multiplicand stream is multiplied by one scalar 64-bit digit. A 64-bit running addend is added to each product. The lower half of each 128-bit result leaves the block as a result digit. The upper half becomes the addend for the next digit, so it acts as a full-word carry. The product of two 64-bit values plus one more 64-bit value always fits in 128 bits, so no separate carry flag is needed.

A row begins with a one-cycle start pulse. The pulse captures the scalar multiplier and the initial carry word, which is zero for a fresh row. Multiplicand digits then arrive least significant first on a valid/ready handshake, and the final digit is flagged. Result digits come out in the same order on a valid-only stream. When the flagged digit's result appears, a done pulse marks it, and the carry-out port holds the final upper half. Only the a×b multiply is pipelined; the carry addition sits in the last stage. This lets a new digit enter every cycle without ever meeting a stale carry.

Top module: `digit_row_mac`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, done and in_ready are all 0.
- R2: A start pulse seen while the unit is idle captures scalar_b and carry_init. in_ready is 1 in the following cycle, and in_ready never rises except in the cycle after a start.
- R3: Each accepted digit a yields out_digit = (a × B + C) mod 2^64, where B is the captured scalar and C is the current carry word.
- R4: C for the first digit of a row is the captured carry_init. C for each later digit is floor((a × B + C) / 2^64) of the digit before it.
- R5: Exactly one output digit appears per accepted digit, in acceptance order. Each appears MUL_STAGES rising edges after the edge that accepted it.
- R6: done is 1 for exactly one cycle, in the cycle where the result of the digit flagged by in_last is on out_digit. In that cycle carry_out holds that digit's upper half.
- R7: After the flagged digit is accepted, in_ready stays 0 until the next start. A start pulse during a row is ignored. Digits offered while idle are not taken.
- R8: Digits offered in consecutive cycles are accepted in consecutive cycles with no stall, and the carry chain stays correct.
- R9: With all-ones scalar, carry_init and digits, each output digit is 0 and every carry word, including carry_out, is all ones (a × b + c = 2^128 − 2^64).
- R10: carry_out changes only in cycles with out_valid or right after a start, so it holds its final value after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a row; captures scalar_b and carry_init when idle |
| carry_init | input | 64 | Carry word added to the first product |
| scalar_b | input | 64 | Scalar digit multiplying every digit of the row |
| in_valid | input | 1 | Multiplicand digit offered |
| in_ready | output | 1 | Unit takes the offered digit at this edge |
| in_digit | input | 64 | Multiplicand digit, least significant first |
| in_last | input | 1 | Marks the most significant digit of the row |
| out_valid | output | 1 | out_digit holds a result digit |
| out_digit | output | 64 | Lower half of a × B + C |
| carry_out | output | 64 | Current carry word; final upper half once done |
| done | output | 1 | One-cycle pulse with the last result digit |

## Verification
The bench builds the unit with MUL_STAGES = 3. This selects the split-product variant: four half-width partial products are registered, folded in the next stage, and then passed through one plain delay stage. A depth of 3 puts three digits in flight at once during back-to-back streams. So the carry feedback is tested exactly where a stale carry would show, and the latency check covers a path that uses every kind of stage. The single-stage full-width variant is not built by this bench.

// File: rtl/digit_row_pkg.sv
package digit_row_pkg;

    localparam int unsigned DIGIT_W = 64;
    localparam int unsigned HALF_W  = DIGIT_W / 2;
    localparam int unsigned WIDE_W  = 2 * DIGIT_W;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [HALF_W-1:0]  half_t;
    typedef logic [WIDE_W-1:0]  wide_t;

    typedef enum logic [1:0] {
        ROW_IDLE  = 2'd0,
        ROW_FEED  = 2'd1,
        ROW_DRAIN = 2'd2
    } row_state_e;

    // four half-width partial products of one digit, in flight
    typedef struct packed {
        logic   vld;
        logic   last;
        digit_t p_ll;
        digit_t p_lh;
        digit_t p_hl;
        digit_t p_hh;
    } part_beat_t;

    // full double-width product of one digit, in flight
    typedef struct packed {
        logic  vld;
        logic  last;
        wide_t prod;
    } prod_beat_t;

    function automatic digit_t half_mul(input half_t x, input half_t y);
        return digit_t'(x) * digit_t'(y);
    endfunction

    function automatic wide_t fold_parts(input digit_t ll, input digit_t lh,
                                         input digit_t hl, input digit_t hh);
        wide_t acc;
        acc = {hh, ll};
        acc = acc + (wide_t'(lh) << HALF_W);
        acc = acc + (wide_t'(hl) << HALF_W);
        return acc;
    endfunction

endpackage

// File: rtl/row_ctrl.sv
module row_ctrl
    import digit_row_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    input  logic tail_last_fire,
    output logic in_ready,
    output logic accept,
    output logic load
);

    row_state_e state_q, state_d;

    assign in_ready = (state_q == ROW_FEED);
    assign accept   = in_ready && in_valid;
    assign load     = start && (state_q == ROW_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROW_IDLE:  if (start)              state_d = ROW_FEED;
            ROW_FEED:  if (accept && in_last)  state_d = ROW_DRAIN;
            ROW_DRAIN: if (tail_last_fire)     state_d = ROW_IDLE;
            default:                           state_d = ROW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ROW_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/mul_pipe.sv
module mul_pipe
    import digit_row_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_fire,
    input  logic       in_last,
    input  digit_t     a,
    input  digit_t     b,
    output prod_beat_t tail
);

    generate
        if (STAGES <= 1) begin : g_flat
            prod_beat_t one_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    one_q <= '0;
                end else begin
                    one_q.vld  <= in_fire;
                    one_q.last <= in_fire && in_last;
                    one_q.prod <= wide_t'(a) * wide_t'(b);
                end
            end
            assign tail = one_q;
        end else begin : g_split
            localparam int unsigned CHAIN_N = STAGES - 1;
            part_beat_t parts_q;
            prod_beat_t chain_q [CHAIN_N];

            always_ff @(posedge clk) begin
                if (rst) begin
                    parts_q <= '0;
                end else begin
                    parts_q.vld  <= in_fire;
                    parts_q.last <= in_fire && in_last;
                    parts_q.p_ll <= half_mul(a[HALF_W-1:0],      b[HALF_W-1:0]);
                    parts_q.p_lh <= half_mul(a[HALF_W-1:0],      b[DIGIT_W-1:HALF_W]);
                    parts_q.p_hl <= half_mul(a[DIGIT_W-1:HALF_W], b[HALF_W-1:0]);
                    parts_q.p_hh <= half_mul(a[DIGIT_W-1:HALF_W], b[DIGIT_W-1:HALF_W]);
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < CHAIN_N; i++) chain_q[i] <= '0;
                end else begin
                    chain_q[0].vld  <= parts_q.vld;
                    chain_q[0].last <= parts_q.last;
                    chain_q[0].prod <= fold_parts(parts_q.p_ll, parts_q.p_lh,
                                                  parts_q.p_hl, parts_q.p_hh);
                    for (int i = 1; i < CHAIN_N; i++) chain_q[i] <= chain_q[i-1];
                end
            end

            assign tail = chain_q[CHAIN_N-1];
        end
    endgenerate

endmodule

// File: rtl/carry_accum.sv
module carry_accum
    import digit_row_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  digit_t     carry_init,
    input  prod_beat_t beat,
    output logic       out_valid,
    output digit_t     out_digit,
    output digit_t     carry_q,
    output logic       done
);

    wide_t sum;
    assign sum = beat.prod + wide_t'(carry_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q   <= '0;
            out_digit <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            out_valid <= beat.vld;
            done      <= beat.vld && beat.last;
            if (load) begin
                carry_q <= carry_init;
            end else if (beat.vld) begin
                carry_q   <= sum[WIDE_W-1:DIGIT_W];
                out_digit <= sum[DIGIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/digit_row_mac.sv
module digit_row_mac
    import digit_row_pkg::*;
#(
    parameter int unsigned MUL_STAGES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] carry_init,
    input  logic [63:0] scalar_b,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_digit,
    input  logic        in_last,
    output logic        out_valid,
    output logic [63:0] out_digit,
    output logic [63:0] carry_out,
    output logic        done
);

    logic       accept;
    logic       load;
    digit_t     scalar_q;
    prod_beat_t tail;

    always_ff @(posedge clk) begin
        if (rst)       scalar_q <= '0;
        else if (load) scalar_q <= scalar_b;
    end

    row_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .in_valid       (in_valid),
        .in_last        (in_last),
        .tail_last_fire (tail.vld && tail.last),
        .in_ready       (in_ready),
        .accept         (accept),
        .load           (load)
    );

    mul_pipe #(.STAGES(MUL_STAGES)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .in_fire (accept),
        .in_last (in_last),
        .a       (in_digit),
        .b       (scalar_q),
        .tail    (tail)
    );

    carry_accum u_acc (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .carry_init (carry_init),
        .beat       (tail),
        .out_valid  (out_valid),
        .out_digit  (out_digit),
        .carry_q    (carry_out),
        .done       (done)
    );

endmodule

// File: rtl/digit_row_mac_chk.sv
module digit_row_mac_chk #(
    parameter int unsigned MUL_STAGES = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [63:0] carry_out,
    input logic        done
);

    logic [7:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) inflight_q <= '0;
        else     inflight_q <= inflight_q + 8'(in_valid && in_ready) - 8'(out_valid);
    end

    AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> $past(start)); // R2

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight_q != 8'd0)); // R5

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= 8'(MUL_STAGES + 1)); // R5

    AST_DONE_WITH_DIGIT: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready); // R7

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(start)) |-> $stable(carry_out)); // R10

endmodule

bind digit_row_mac digit_row_mac_chk #(.MUL_STAGES(MUL_STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .carry_out (carry_out),
    .done      (done)
);

// File: tb/digit_row_mac_test.sv
module digit_row_mac_test;

    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 3;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct {
        logic [63:0] lo;
        logic [63:0] hi;
        logic        last;
        int          cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] carry_init;
    logic [63:0] scalar_b;
    logic        in_valid;
    logic        in_ready;
    logic [63:0] in_digit;
    logic        in_last;
    logic        out_valid;
    logic [63:0] out_digit;
    logic [63:0] carry_out;
    logic        done;

    int          errors = 0;
    int          checks = 0;
    int          cyc    = 0;
    bit          over   = 1'b0;
    exp_t        q[$];
    logic [63:0] m_b;
    logic [63:0] m_c;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    digit_row_mac #(.MUL_STAGES(STAGES)) uut (
        .clk(clk), .rst(rst), .start(start), .carry_init(carry_init),
        .scalar_b(scalar_b), .in_valid(in_valid), .in_ready(in_ready),
        .in_digit(in_digit), .in_last(in_last), .out_valid(out_valid),
        .out_digit(out_digit), .carry_out(carry_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // monitor: pops expected digits as results appear
    always @(negedge clk) begin
        if (!rst && !over) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected output digit", out_digit, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_digit === e.lo, "R3", "result digit", out_digit, e.lo);
                    chk(cyc == e.cyc, "R5", "output cycle", 64'(cyc), 64'(e.cyc));
                    chk(done === e.last, "R6", "done flag", 64'(done), 64'(e.last));
                    if (e.last)
                        chk(carry_out === e.hi, "R4", "final carry word", carry_out, e.hi);
                end
            end else if (done) begin
                chk(1'b0, "R6", "done without digit", 64'(done), 64'd0);
            end
        end
    end

    task automatic begin_row(input logic [63:0] b, input logic [63:0] c);
        @(negedge clk);
        start = 1'b1; scalar_b = b; carry_init = c;
        m_b = b; m_c = c;
        @(negedge clk);
        start = 1'b0; scalar_b = '0; carry_init = '0;
        chk(in_ready === 1'b1, "R2", "ready after start", 64'(in_ready), 64'd1);
    endtask

    task automatic send(input logic [63:0] d, input bit last, input int gap);
        logic [127:0] s;
        exp_t e;
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
        in_valid = 1'b1; in_digit = d; in_last = last;
        while (!in_ready) @(negedge clk);
        s = {64'd0, d} * {64'd0, m_b} + {64'd0, m_c};
        e.lo = s[63:0]; e.hi = s[127:64]; e.last = last; e.cyc = cyc + 1 + STAGES;
        q.push_back(e);
        m_c = s[127:64];
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic poke_start(input logic [63:0] b, input logic [63:0] c);
        start = 1'b1; scalar_b = b; carry_init = c;
        @(negedge clk);
        start = 1'b0; scalar_b = '0; carry_init = '0;
        chk(in_ready === 1'b1, "R7", "start mid-row kept row open", 64'(in_ready), 64'd1);
    endtask

    task automatic finish_row();
        logic [63:0] held;
        while (q.size() != 0) @(negedge clk);
        chk(in_ready === 1'b0, "R7", "ready low after last", 64'(in_ready), 64'd0);
        chk(carry_out === m_c, "R4", "carry word after row", carry_out, m_c);
        held = carry_out;
        repeat (3) @(negedge clk);
        chk(carry_out === held, "R10", "carry held after done", carry_out, held);
        chk(done === 1'b0, "R6", "done is a pulse", 64'(done), 64'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; carry_init = '0; scalar_b = '0;
        in_valid = 1'b0; in_digit = '0; in_last = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(done === 1'b0, "R1", "done in reset", 64'(done), 64'd0);
        chk(in_ready === 1'b0, "R1", "in_ready in reset", 64'(in_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b0, "R1", "in_ready after reset", 64'(in_ready), 64'd0);

        // R7: digits offered while idle are not taken
        in_valid = 1'b1; in_digit = 64'd77; in_last = 1'b1;
        repeat (STAGES + 3) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R7", "idle digit produced output", 64'(out_valid), 64'd0);
        end
        in_valid = 1'b0; in_last = 1'b0;

        // R3 R4 R8: back-to-back digits, fresh row with zero carry
        begin_row(64'd3, 64'd0);
        send(64'd5, 1'b0, 0);
        send(ONES, 1'b0, 0);
        send(ONES, 1'b0, 0);
        send(64'd9, 1'b1, 0);
        finish_row();

        // R9: all-ones operands and carry
        begin_row(ONES, ONES);
        send(ONES, 1'b0, 0);
        send(ONES, 1'b0, 0);
        send(ONES, 1'b1, 0);
        finish_row();
        chk(carry_out === ONES, "R9", "all-ones carry", carry_out, ONES);

        // R5: gaps between digits, nonzero initial carry
        begin_row(64'h1234_5678_9ABC_DEF1, 64'h0000_0000_0000_00FF);
        send(64'hFEDC_BA98_7654_3210, 1'b0, 0);
        send(64'h8000_0000_0000_0001, 1'b0, 2);
        send(64'h0000_0001_0000_0000, 1'b0, 1);
        send(64'hDEAD_BEEF_CAFE_F00D, 1'b1, 3);
        finish_row();

        // R7: start during a row is ignored
        begin_row(64'hA5A5_5A5A_0F0F_F0F0, 64'd5);
        send(64'h0123_4567_89AB_CDEF, 1'b0, 0);
        send(ONES, 1'b0, 0);
        poke_start(64'd2, 64'hFFFF_0000_FFFF_0000);
        send(64'h7777_8888_9999_AAAA, 1'b0, 0);
        send(64'h0000_0000_0000_0002, 1'b1, 1);
        finish_row();

        // R6: single-digit row
        begin_row(64'hFFFF_FFFF_0000_0001, 64'h1111_2222_3333_4444);
        send(64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 0);
        finish_row();

        over = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            chk(1'b0, "R5", "watchdog expired", 64'(q.size()), 64'd0);
            report();
            $finish;
        end
    end

endmodule